// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block decides, every cycle, which resident thread group (warp) feeds the SIMD functional units of one core. It keeps one stall bit per warp context. Issue-stall events tagged with a warp number set that warp's bit. Completion events tagged with a warp number clear it. A warp is a candidate when the resident mask marks it present and its stall bit is clear. The more contexts are resident, the more latency the core can hide.

Two levels of multithreading combine here. At the fine level, a chosen warp keeps the issue slot for a fixed number of consecutive cycles, one cycle per interleaved thread, so each pipelined lane receives a new thread every cycle. At the coarse level, when a slot ends, the next warp is chosen round-robin among the candidates. The search starts just after the warp that was picked last. A stalled warp is therefore skipped and the lanes stay busy. This adds latency to single threads but raises overall throughput. The outputs (valid flag, warp number, thread index) are registered.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is high, and in the cycle after it is released, issue_valid is 0. Reset clears every stall bit.
- R2: A selected warp holds the slot for SLOT_CYCLES (default 4) consecutive cycles. issue_warp stays fixed and issue_thread counts 0,1,2,3. issue_thread is 0 on the first cycle of every slot.
- R3: At the end of a slot, the next warp is the first candidate found by searching upward from the last selected warp plus one, wrapping from 31 to 0. After reset the search starts at warp 0.
- R4: A stall event (stall_valid with stall_id) marks that warp stalled. A warp that is stalled, or that has a stall event in the same cycle a selection is made, is not selected.
- R5: A completion event (wake_valid with wake_id) clears that warp's stall bit at the next clock edge. The warp can be selected at the edge after that.
- R6: When a slot is not in progress and no warp is a candidate, issue_valid is 0 in the next cycle.
- R7: A stall event and a completion event for the same warp in the same cycle leave that warp stalled.
- R8: A warp whose warp_resident bit is 0 is never selected, even when its stall bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_resident | input | NUM_WARPS | One bit per warp context that is loaded in the core |
| stall_valid | input | 1 | Stall event strobe |
| stall_id | input | $clog2(NUM_WARPS) | Warp that stalls |
| wake_valid | input | 1 | Completion event strobe |
| wake_id | input | $clog2(NUM_WARPS) | Warp whose pending result has returned |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Warp that owns the issue slot |
| issue_thread | output | $clog2(SLOT_CYCLES) | Interleaved thread index within the warp |

## Verification
The assertions assume that warp_resident changes only between slots and never removes the warp that currently holds the slot. They also assume that stall and completion events carry in-range warp numbers. The directed stimulus changes residency only right after reset or while the scheduler is idle. Events are driven as single-cycle pulses on the falling clock edge, so each one is seen by exactly one rising edge.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int unsigned DEF_WARPS = 32;
  localparam int unsigned DEF_SLOT  = 4;

  function automatic int unsigned safe_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/warp_stall_track.sv
module warp_stall_track #(
  parameter int unsigned NUM_WARPS = warp_sched_pkg::DEF_WARPS,
  localparam int unsigned IDW = warp_sched_pkg::safe_bits(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] resident,
  input  logic                 set_valid,
  input  logic [IDW-1:0]       set_id,
  input  logic                 clr_valid,
  input  logic [IDW-1:0]       clr_id,
  output logic [NUM_WARPS-1:0] stalled_q,
  output logic [NUM_WARPS-1:0] cand
);
  logic [NUM_WARPS-1:0] set_mask;
  logic [NUM_WARPS-1:0] clr_mask;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_dec
    assign set_mask[w] = set_valid && (set_id == IDW'(w));
    assign clr_mask[w] = clr_valid && (clr_id == IDW'(w));
  end

  always_ff @(posedge clk) begin
    if (rst) stalled_q <= '0;
    else     stalled_q <= (stalled_q & ~clr_mask) | set_mask;
  end

  // a warp stalling right now is already excluded from this cycle's pick
  assign cand = resident & ~stalled_q & ~set_mask;
endmodule

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int unsigned NUM_WARPS = warp_sched_pkg::DEF_WARPS,
  localparam int unsigned IDW = warp_sched_pkg::safe_bits(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] req,
  input  logic [IDW-1:0]       last,
  output logic                 found,
  output logic [IDW-1:0]       pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      int j;
      j = (int'(last) + i) % NUM_WARPS;
      if (!found && req[j]) begin
        found = 1'b1;
        pick  = j[IDW-1:0];
      end
    end
  end
endmodule

// File: rtl/warp_slot_ctrl.sv
module warp_slot_ctrl #(
  parameter int unsigned NUM_WARPS   = warp_sched_pkg::DEF_WARPS,
  parameter int unsigned SLOT_CYCLES = warp_sched_pkg::DEF_SLOT,
  localparam int unsigned IDW = warp_sched_pkg::safe_bits(NUM_WARPS),
  localparam int unsigned TW  = warp_sched_pkg::safe_bits(SLOT_CYCLES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           found,
  input  logic [IDW-1:0] pick,
  output logic [IDW-1:0] last_q,
  output logic           valid_q,
  output logic [IDW-1:0] warp_q,
  output logic [TW-1:0]  thread_q
);
  localparam logic [TW-1:0] THR_END = TW'(SLOT_CYCLES - 1);
  logic mid_slot;

  assign mid_slot = valid_q && (thread_q != THR_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      warp_q   <= '0;
      thread_q <= '0;
      last_q   <= IDW'(NUM_WARPS - 1);
    end else if (mid_slot) begin
      thread_q <= thread_q + 1'b1;
    end else if (found) begin
      valid_q  <= 1'b1;
      warp_q   <= pick;
      thread_q <= '0;
      last_q   <= pick;
    end else begin
      valid_q  <= 1'b0;
      thread_q <= '0;
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int unsigned NUM_WARPS   = warp_sched_pkg::DEF_WARPS,
  parameter int unsigned SLOT_CYCLES = warp_sched_pkg::DEF_SLOT,
  localparam int unsigned IDW = warp_sched_pkg::safe_bits(NUM_WARPS),
  localparam int unsigned TW  = warp_sched_pkg::safe_bits(SLOT_CYCLES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_resident,
  input  logic                 stall_valid,
  input  logic [IDW-1:0]       stall_id,
  input  logic                 wake_valid,
  input  logic [IDW-1:0]       wake_id,
  output logic                 issue_valid,
  output logic [IDW-1:0]       issue_warp,
  output logic [TW-1:0]        issue_thread
);
  logic [NUM_WARPS-1:0] stalled_q;
  logic [NUM_WARPS-1:0] cand;
  logic                 found;
  logic [IDW-1:0]       pick;
  logic [IDW-1:0]       last_q;

  warp_stall_track #(.NUM_WARPS(NUM_WARPS)) u_track (
    .clk(clk), .rst(rst), .resident(warp_resident),
    .set_valid(stall_valid), .set_id(stall_id),
    .clr_valid(wake_valid), .clr_id(wake_id),
    .stalled_q(stalled_q), .cand(cand)
  );

  warp_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .req(cand), .last(last_q), .found(found), .pick(pick)
  );

  warp_slot_ctrl #(.NUM_WARPS(NUM_WARPS), .SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk(clk), .rst(rst), .found(found), .pick(pick), .last_q(last_q),
    .valid_q(issue_valid), .warp_q(issue_warp), .thread_q(issue_thread)
  );
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int unsigned NUM_WARPS   = 32,
  parameter int unsigned SLOT_CYCLES = 4,
  localparam int unsigned IDW = warp_sched_pkg::safe_bits(NUM_WARPS),
  localparam int unsigned TW  = warp_sched_pkg::safe_bits(SLOT_CYCLES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_WARPS-1:0] warp_resident,
  input logic                 stall_valid,
  input logic [IDW-1:0]       stall_id,
  input logic                 issue_valid,
  input logic [IDW-1:0]       issue_warp,
  input logic [TW-1:0]        issue_thread,
  input logic [NUM_WARPS-1:0] stalled_q
);
  localparam logic [TW-1:0] THR_END = TW'(SLOT_CYCLES - 1);
  logic mid;
  logic start;
  assign mid   = issue_valid && (issue_thread != THR_END);
  assign start = issue_valid && (issue_thread == '0);

  p_burst_hold_r2: assert property (@(posedge clk) disable iff (rst)
    mid |=> issue_valid && issue_warp == $past(issue_warp)
            && issue_thread == $past(issue_thread) + 1'b1);

  p_slot_begin_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(issue_valid) |-> issue_thread == '0);

  p_pick_resident_r8: assert property (@(posedge clk) disable iff (rst)
    start |-> ((($past(warp_resident)) >> issue_warp) & 1) != 0);

  p_pick_unstalled_r4: assert property (@(posedge clk) disable iff (rst)
    start |-> ((($past(stalled_q)) >> issue_warp) & 1) == 0
              && !($past(stall_valid) && $past(stall_id) == issue_warp));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!mid && ((warp_resident & ~stalled_q) == '0)) |=> !issue_valid);
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .SLOT_CYCLES(SLOT_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .warp_resident(warp_resident),
  .stall_valid(stall_valid), .stall_id(stall_id),
  .issue_valid(issue_valid), .issue_warp(issue_warp),
  .issue_thread(issue_thread), .stalled_q(stalled_q)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  localparam int NW = 32;
  logic          clk = 1'b0;
  logic          rst;
  logic [NW-1:0] warp_resident;
  logic          stall_valid, wake_valid;
  logic [4:0]    stall_id, wake_id;
  logic          issue_valid;
  logic [4:0]    issue_warp;
  logic [1:0]    issue_thread;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  warp_issue_sched dut_i (
    .clk(clk), .rst(rst), .warp_resident(warp_resident),
    .stall_valid(stall_valid), .stall_id(stall_id),
    .wake_valid(wake_valid), .wake_id(wake_id),
    .issue_valid(issue_valid), .issue_warp(issue_warp),
    .issue_thread(issue_thread)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic ev, input int ew, input int et);
    n_chk++;
    if (issue_valid !== ev || (ev && (issue_warp !== 5'(ew) || issue_thread !== 2'(et)))) begin
      n_bad++;
      $display("FAIL %s: got v=%0b w=%0d t=%0d, expected v=%0b w=%0d t=%0d",
               req, issue_valid, issue_warp, issue_thread, ev, ew, et);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; warp_resident = '0;
    stall_valid = 1'b0; wake_valid = 1'b0; stall_id = '0; wake_id = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic run_slot(input string req, input int w);
    for (int t = 0; t < 4; t++) begin
      step();
      chk(req, 1'b1, w, t);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 1'b0, 0, 0);
    step();
    chk("R1/R6 idle no resident", 1'b0, 0, 0);
  endtask

  task automatic t_single();
    do_reset();
    warp_resident = NW'(1) << 5;
    run_slot("R2 slot", 5);
    run_slot("R2 reselect", 5);
  endtask

  task automatic t_round_robin();
    do_reset();
    warp_resident = (NW'(1) << 3) | (NW'(1) << 7) | (NW'(1) << 20);
    run_slot("R3/R8 first", 3);
    run_slot("R3/R8 second", 7);
    run_slot("R3/R8 third", 20);
    run_slot("R3 wrap", 3);
  endtask

  task automatic t_wrap();
    do_reset();
    warp_resident = NW'(1) | (NW'(1) << 31);
    run_slot("R3 w0", 0);
    run_slot("R3 w31", 31);
    run_slot("R3 wrap 31->0", 0);
  endtask

  task automatic t_stall_wake();
    do_reset();
    warp_resident = NW'(3) << 1;
    step(); chk("R2 w1 t0", 1'b1, 1, 0);
    stall_valid = 1'b1; stall_id = 5'd1;
    step(); chk("R4 slot continues", 1'b1, 1, 1);
    stall_valid = 1'b0;
    step(); chk("R2 w1 t2", 1'b1, 1, 2);
    step(); chk("R2 w1 t3", 1'b1, 1, 3);
    run_slot("R4 skip stalled", 2);
    step(); chk("R4 w2 again", 1'b1, 2, 0);
    wake_valid = 1'b1; wake_id = 5'd1;
    step(); chk("R5 w2 t1", 1'b1, 2, 1);
    wake_valid = 1'b0;
    step(); chk("R5 w2 t2", 1'b1, 2, 2);
    step(); chk("R5 w2 t3", 1'b1, 2, 3);
    run_slot("R5 woken warp picked", 1);
  endtask

  task automatic t_same_cycle();
    do_reset();
    warp_resident = NW'(1) << 4;
    run_slot("R2 w4", 4);
    stall_valid = 1'b1; stall_id = 5'd4;
    step(); chk("R4 stall at slot end blocks", 1'b0, 0, 0);
    stall_valid = 1'b0;
    step(); chk("R6 all stalled", 1'b0, 0, 0);
    stall_valid = 1'b1; wake_valid = 1'b1; wake_id = 5'd4;
    step(); chk("R7 same-cycle events", 1'b0, 0, 0);
    stall_valid = 1'b0; wake_valid = 1'b0;
    step(); chk("R7 stall wins", 1'b0, 0, 0);
    wake_valid = 1'b1;
    step(); chk("R5 not yet eligible", 1'b0, 0, 0);
    wake_valid = 1'b0;
    step(); chk("R5 eligible next cycle", 1'b1, 4, 0);
  endtask

  task automatic t_nonresident();
    do_reset();
    warp_resident = NW'(1) << 9;
    run_slot("R8 only resident", 9);
    run_slot("R8 still only resident", 9);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_single();
    t_round_robin();
    t_wrap();
    t_stall_wake();
    t_same_cycle();
    t_nonresident();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule